// File: doc/BRIEF.md
# Decimation Rate Divider with Filter Configuration Registers

This block turns the full-rate input sample clock into a single-cycle enable at the decimated rate. The period of the enable is a programmable decimation factor. The enable clocks the decimation register, the comb stages and the output register of a decimating filter. It also tells the downstream filter that a new sample is ready. After reset the divider stays idle, with its count held at zero, until a start pulse arrives. From then on it runs until the next reset.

The same block holds four configuration registers, loaded over a parallel bus. A write happens only when the write strobe and the chip select are both high. The 2-bit address picks the register. The registers carry the decimation factor, the comb stage count and its bypass flag, and two filter tap parameters. The block decodes the stage count and the bypass flag into one enable per comb stage.

A new decimation factor does not change the running period at once. The divider adopts it at the next wrap of the counter, so a period in progress is never cut short or stretched.

Top module: `decim_rate_ctrl`

## Requirements
- R1: Synchronous reset gives these values: tick low and divider idle, decimation factor 4, comb stage count 5, bypass 0, tap count 0 and tap rate 0.
- R2: While idle, the tick stays low, whatever the bus does. Sampling `start_i` high puts the divider in the running state at that clock edge.
- R3: With an effective factor N, the tick is high for one cycle in the N-th cycle after the edge that sampled start. Counting the first running cycle as cycle 0, that is cycle N-1. After that it repeats every N cycles.
- R4: A factor of 1 gives a tick in every running cycle. A programmed factor of 0 behaves as 1.
- R5: A register loads only on a clock edge where `bus_wr_i` and `bus_cs_i` are both high. The address map is as follows:
  - Address 0 holds the factor in data bits [9:0].
  - Address 1 holds the stage count in bits [2:0] and bypass in bit 3.
  - Address 2 holds the tap count in bits [7:0].
  - Address 3 holds the tap rate in bits [7:0].
  - Data bits outside a field are ignored.
- R6: A factor written while the divider runs takes effect at the next wrap. If the write lands on the edge that ends a tick cycle, the wrap at that edge still loads the old value, and the new value applies one period later.
- R7: A stage count written above 5 is stored as 5.
- R8: Comb enable bit k is high exactly when bypass is 0 and k is less than the stage count. With bypass set, all enable bits are low.
- R9: A start pulse while running has no effect on the tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse that releases the divider |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_cs_i | input | 1 | Bus chip select |
| bus_addr_i | input | 2 | Register address |
| bus_data_i | input | 16 | Write data |
| dec_tick_o | output | 1 | Decimated-rate enable / new-sample flag |
| dec_factor_o | output | 10 | Programmed decimation factor |
| comb_stages_o | output | 3 | Comb stage count |
| comb_bypass_o | output | 1 | Comb bypass flag |
| comb_en_o | output | 5 | Per-stage comb enables |
| fir_taps_o | output | 8 | Filter tap count |
| fir_rate_o | output | 8 | Filter tap rate |

## Verification
A bus write to the factor register and a counter wrap can fall on the same clock edge. The bench provokes this by issuing the write in the very cycle that carries a tick. It then judges the tick train against an arithmetic model in which that wrap still loads the previous factor. A second run writes in mid-period and expects the change at the first following wrap. Start pulses issued during running, and writes without chip select, are judged by an unchanged tick phase and unchanged register outputs.

// File: rtl/decim_pkg.sv
package decim_pkg;

    localparam int BUS_W       = 16;
    localparam int ADDR_W      = 2;
    localparam int NUM_REGS    = 1 << ADDR_W;
    localparam int FACTOR_W    = 10;
    localparam int MAX_STAGES  = 5;
    localparam int STG_W       = $clog2(MAX_STAGES + 1);
    localparam int FIR_W       = 8;
    localparam int BYP_BIT     = STG_W;

    localparam logic [FACTOR_W-1:0] RST_FACTOR = FACTOR_W'(4);
    localparam logic [STG_W-1:0]    RST_STAGES = STG_W'(MAX_STAGES);

    typedef enum logic [ADDR_W-1:0] {
        REG_FACTOR = 2'd0,
        REG_COMB   = 2'd1,
        REG_TAPS   = 2'd2,
        REG_RATE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [FACTOR_W-1:0] factor;
        logic [STG_W-1:0]    stages;
        logic                bypass;
        logic [FIR_W-1:0]    taps;
        logic [FIR_W-1:0]    rate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        factor: RST_FACTOR,
        stages: RST_STAGES,
        bypass: 1'b0,
        taps:   '0,
        rate:   '0
    };

    function automatic logic [FACTOR_W-1:0] eff_factor(input logic [FACTOR_W-1:0] f);
        return (f == '0) ? FACTOR_W'(1) : f;
    endfunction

    function automatic logic [STG_W-1:0] clamp_stages(input logic [STG_W-1:0] v);
        return (v > STG_W'(MAX_STAGES)) ? STG_W'(MAX_STAGES) : v;
    endfunction

endpackage

// File: rtl/decim_cfg_regs.sv
module decim_cfg_regs
    import decim_pkg::*;
#(
    parameter int P_BUS_W  = BUS_W,
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic                cs_i,
    input  logic [P_ADDR_W-1:0] addr_i,
    input  logic [P_BUS_W-1:0]  data_i,
    output cfg_t                cfg_o
);

    localparam int P_NREGS = 1 << P_ADDR_W;

    logic [P_NREGS-1:0] sel;
    cfg_t               cfg_q;

    for (genvar a = 0; a < P_NREGS; a++) begin : g_sel
        assign sel[a] = wr_i && cs_i && (addr_i == P_ADDR_W'(a));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (sel[REG_FACTOR]) cfg_q.factor <= data_i[FACTOR_W-1:0];
            if (sel[REG_COMB]) begin
                cfg_q.stages <= clamp_stages(data_i[STG_W-1:0]);
                cfg_q.bypass <= data_i[BYP_BIT];
            end
            if (sel[REG_TAPS])   cfg_q.taps   <= data_i[FIR_W-1:0];
            if (sel[REG_RATE])   cfg_q.rate   <= data_i[FIR_W-1:0];
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/decim_divider.sv
module decim_divider
    import decim_pkg::*;
#(
    parameter int P_FACTOR_W = FACTOR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [P_FACTOR_W-1:0] factor_i,
    output logic                  tick_o,
    output logic                  run_o,
    output logic [P_FACTOR_W-1:0] act_o
);

    logic                  run_q;
    logic [P_FACTOR_W-1:0] cnt_q;
    logic [P_FACTOR_W-1:0] act_q;
    logic [P_FACTOR_W-1:0] next_act;
    logic                  wrap;

    assign next_act = (factor_i == '0) ? P_FACTOR_W'(1) : factor_i;
    assign wrap     = run_q && (cnt_q == act_q - P_FACTOR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            act_q <= P_FACTOR_W'(1);
        end else begin
            if (start_i) run_q <= 1'b1;
            if (!run_q || wrap) begin
                cnt_q <= '0;
                act_q <= next_act;
            end else begin
                cnt_q <= cnt_q + P_FACTOR_W'(1);
            end
        end
    end

    assign tick_o = wrap;
    assign run_o  = run_q;
    assign act_o  = act_q;

endmodule

// File: rtl/decim_comb_enable.sv
module decim_comb_enable
    import decim_pkg::*;
#(
    parameter int P_STAGES = MAX_STAGES,
    parameter int P_STG_W  = STG_W
) (
    input  logic [P_STG_W-1:0]  stages_i,
    input  logic                bypass_i,
    output logic [P_STAGES-1:0] en_o
);

    for (genvar k = 0; k < P_STAGES; k++) begin : g_stage
        assign en_o[k] = !bypass_i && (stages_i > P_STG_W'(k));
    end

endmodule

// File: rtl/decim_rate_ctrl.sv
module decim_rate_ctrl
    import decim_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  bus_wr_i,
    input  logic                  bus_cs_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [BUS_W-1:0]      bus_data_i,
    output logic                  dec_tick_o,
    output logic [FACTOR_W-1:0]   dec_factor_o,
    output logic [STG_W-1:0]      comb_stages_o,
    output logic                  comb_bypass_o,
    output logic [MAX_STAGES-1:0] comb_en_o,
    output logic [FIR_W-1:0]      fir_taps_o,
    output logic [FIR_W-1:0]      fir_rate_o
);

    cfg_t                cfg;
    logic                run;
    logic [FACTOR_W-1:0] act_factor;

    decim_cfg_regs #(
        .P_BUS_W  (BUS_W),
        .P_ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (bus_wr_i),
        .cs_i   (bus_cs_i),
        .addr_i (bus_addr_i),
        .data_i (bus_data_i),
        .cfg_o  (cfg)
    );

    decim_divider #(
        .P_FACTOR_W (FACTOR_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .factor_i (cfg.factor),
        .tick_o   (dec_tick_o),
        .run_o    (run),
        .act_o    (act_factor)
    );

    decim_comb_enable #(
        .P_STAGES (MAX_STAGES),
        .P_STG_W  (STG_W)
    ) u_comb (
        .stages_i (cfg.stages),
        .bypass_i (cfg.bypass),
        .en_o     (comb_en_o)
    );

    assign dec_factor_o  = cfg.factor;
    assign comb_stages_o = cfg.stages;
    assign comb_bypass_o = cfg.bypass;
    assign fir_taps_o    = cfg.taps;
    assign fir_rate_o    = cfg.rate;

endmodule

// File: rtl/decim_rate_ctrl_sva.sv
module decim_rate_ctrl_sva
    import decim_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic                  bus_wr_i,
    input logic                  bus_cs_i,
    input logic                  dec_tick_o,
    input logic                  run,
    input logic [FACTOR_W-1:0]   act_factor,
    input logic [FACTOR_W-1:0]   dec_factor_o,
    input logic [STG_W-1:0]      comb_stages_o,
    input logic                  comb_bypass_o,
    input logic [MAX_STAGES-1:0] comb_en_o,
    input logic [FIR_W-1:0]      fir_taps_o,
    input logic [FIR_W-1:0]      fir_rate_o
);

    logic [FACTOR_W:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || !run || dec_tick_o) gap_q <= '0;
        else                           gap_q <= gap_q + 1'b1;
    end

    AST_START_RUNS:   assert property (@(posedge clk) disable iff (rst) start_i |=> run);                 // R2
    AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (rst) !run |-> !dec_tick_o);            // R2
    AST_TICK_GAP:     assert property (@(posedge clk) disable iff (rst)
                          dec_tick_o |-> (gap_q == {1'b0, act_factor} - 1'b1));                        // R3
    AST_ACT_NONZERO:  assert property (@(posedge clk) disable iff (rst) act_factor != '0);             // R4
    AST_CFG_HOLD:     assert property (@(posedge clk) disable iff (rst)
                          !(bus_wr_i && bus_cs_i) |=> $stable({dec_factor_o, comb_stages_o,
                                                              comb_bypass_o, fir_taps_o, fir_rate_o})); // R5
    AST_STAGE_CAP:    assert property (@(posedge clk) disable iff (rst)
                          comb_stages_o <= STG_W'(MAX_STAGES));                                         // R7
    AST_BYPASS_MUTES: assert property (@(posedge clk) disable iff (rst)
                          comb_bypass_o |-> (comb_en_o == '0));                                         // R8
    AST_RUN_STICKY:   assert property (@(posedge clk) disable iff (rst) run |=> run);                    // R9

endmodule

bind decim_rate_ctrl decim_rate_ctrl_sva u_sva (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .bus_wr_i      (bus_wr_i),
    .bus_cs_i      (bus_cs_i),
    .dec_tick_o    (dec_tick_o),
    .run           (run),
    .act_factor    (act_factor),
    .dec_factor_o  (dec_factor_o),
    .comb_stages_o (comb_stages_o),
    .comb_bypass_o (comb_bypass_o),
    .comb_en_o     (comb_en_o),
    .fir_taps_o    (fir_taps_o),
    .fir_rate_o    (fir_rate_o)
);

// File: tb/decim_rate_ctrl_test.sv
module decim_rate_ctrl_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic        bus_cs_i = 1'b0;
    logic [1:0]  bus_addr_i = '0;
    logic [15:0] bus_data_i = '0;
    logic        dec_tick_o;
    logic [9:0]  dec_factor_o;
    logic [2:0]  comb_stages_o;
    logic        comb_bypass_o;
    logic [4:0]  comb_en_o;
    logic [7:0]  fir_taps_o;
    logic [7:0]  fir_rate_o;

    int n_run  = 0;
    int n_fail = 0;

    decim_rate_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .bus_wr_i      (bus_wr_i),
        .bus_cs_i      (bus_cs_i),
        .bus_addr_i    (bus_addr_i),
        .bus_data_i    (bus_data_i),
        .dec_tick_o    (dec_tick_o),
        .dec_factor_o  (dec_factor_o),
        .comb_stages_o (comb_stages_o),
        .comb_bypass_o (comb_bypass_o),
        .comb_en_o     (comb_en_o),
        .fir_taps_o    (fir_taps_o),
        .fir_rate_o    (fir_rate_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        n_run++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic wr, input logic cs, input int addr, input int data);
        bus_wr_i   = wr;
        bus_cs_i   = cs;
        bus_addr_i = 2'(addr);
        bus_data_i = 16'(data);
        @(negedge clk);
        bus_wr_i = 1'b0;
        bus_cs_i = 1'b0;
    endtask

    function automatic int comb_mask(input int st, input int byp);
        int s = (st > 5) ? 5 : st;
        return byp ? 0 : ((1 << s) - 1);
    endfunction

    // Starts the divider and compares the tick per cycle against a period model
    task automatic run_window(input string req, input int n_cyc, input int factor,
                              input int wr_at, input int wr_val, input int rs_at);
        int ph   = 0;
        int pend = factor;
        int per  = (factor == 0) ? 1 : factor;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n_cyc; i++) begin
            bit exp_t;
            exp_t = (ph == per - 1);
            check(req, int'(dec_tick_o), int'(exp_t));
            if (i == wr_at) begin
                bus_wr_i = 1'b1; bus_cs_i = 1'b1; bus_addr_i = 2'd0; bus_data_i = 16'(wr_val);
            end
            if (i == rs_at) start_i = 1'b1;
            @(negedge clk);
            bus_wr_i = 1'b0; bus_cs_i = 1'b0; start_i = 1'b0;
            if (exp_t) begin
                ph  = 0;
                per = (pend == 0) ? 1 : pend;
            end else begin
                ph++;
            end
            if (i == wr_at) pend = wr_val;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset values
        check("R1 tick", int'(dec_tick_o), 0);
        check("R1 factor", int'(dec_factor_o), 4);
        check("R1 stages", int'(comb_stages_o), 5);
        check("R1 bypass", int'(comb_bypass_o), 0);
        check("R1 taps", int'(fir_taps_o), 0);
        check("R1 rate", int'(fir_rate_o), 0);
        check("R8 reset enables", int'(comb_en_o), 5'b11111);

        // R2 idle: no tick while writes happen
        for (int i = 0; i < 6; i++) begin
            bus_write(1'b1, 1'b1, 0, i + 1);
            check("R2 idle tick", int'(dec_tick_o), 0);
        end

        // R3/R4 sweep over factors 0..12
        for (int f = 0; f <= 12; f++) begin
            do_reset();
            bus_write(1'b1, 1'b1, 0, f);
            for (int i = 0; i < 3; i++) begin
                check("R2 before start", int'(dec_tick_o), 0);
                @(negedge clk);
            end
            run_window((f <= 1) ? "R4 unit factor" : "R3 period", 4 * ((f == 0) ? 1 : f) + 3,
                       f, -1, 0, -1);
        end

        // R5 field positions and ignored upper bits
        do_reset();
        bus_write(1'b1, 1'b1, 0, 16'hFC05);
        check("R5 factor field", int'(dec_factor_o), 5);
        bus_write(1'b1, 1'b1, 2, 16'hAB3C);
        check("R5 taps field", int'(fir_taps_o), 8'h3C);
        bus_write(1'b1, 1'b1, 3, 16'h12C7);
        check("R5 rate field", int'(fir_rate_o), 8'hC7);
        bus_write(1'b1, 1'b1, 1, 16'hFFF3);
        check("R5 stages field", int'(comb_stages_o), 3);
        check("R5 bypass field", int'(comb_bypass_o), 0);
        check("R8 three stages", int'(comb_en_o), comb_mask(3, 0));
        // R5 write without chip select, and select without write: ignored
        bus_write(1'b1, 1'b0, 0, 9);
        check("R5 no cs factor", int'(dec_factor_o), 5);
        bus_write(1'b0, 1'b1, 2, 8'h11);
        check("R5 no wr taps", int'(fir_taps_o), 8'h3C);
        bus_write(1'b1, 1'b0, 1, 16'h0008);
        check("R5 no cs bypass", int'(comb_bypass_o), 0);

        // R7 saturation and R8 decode over every count and bypass
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < 2; b++) begin
                bus_write(1'b1, 1'b1, 1, (b << 3) | s);
                check("R7 stage clamp", int'(comb_stages_o), (s > 5) ? 5 : s);
                check("R8 enables", int'(comb_en_o), comb_mask(s, b));
            end
        end

        // R6 mid-period change
        do_reset();
        bus_write(1'b1, 1'b1, 0, 4);
        run_window("R6 mid-period write", 30, 4, 5, 6, -1);
        // R6 write on the tick cycle
        do_reset();
        bus_write(1'b1, 1'b1, 0, 4);
        run_window("R6 write at wrap", 30, 4, 7, 6, -1);
        // R9 start while running
        do_reset();
        bus_write(1'b1, 1'b1, 0, 4);
        run_window("R9 restart ignored", 20, 4, -1, 0, 5);
        do_reset();
        bus_write(1'b1, 1'b1, 0, 3);
        run_window("R9 restart on tick", 20, 3, -1, 0, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule